// File: doc/BRIEF.md
# PWM/PDM DAC Output Timer

This block is a small timer that produces a one-bit waveform whose long-term average encodes a digital duty value. A low-pass RC network on the pin can turn that waveform into an analog level. A free-running up counter advances on each cycle in which the clock-enable strobe is high. The active duty value sets how many counter clocks of each period drive the pin high. The same duty value serves two shapes. In width mode the high clocks form one block at the start of the period. In density mode they are spread across the period as single-clock pulses, which eases the filtering.

Software writes the duty value into a holding register. The value, and the mode select, take effect only when the counter wraps. Every wrap can also raise a one-cycle interrupt, unless the interrupt is masked.

Top module: `dac_pulse_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 8). It advances by one on every clock where `tick_i` is high, giving a period of 2**CNT_W ticks, and wraps from its maximum value to 0.
- R2: In width mode (`mode_pdm_i` = 0 applied), after the edge that sets the count to c, `dac_o` is high exactly when c < active duty. A duty of 0 keeps the pin low for the whole period.
- R3: In density mode (`mode_pdm_i` = 1 applied), `dac_o` is high exactly when the bit-reversed count is below the active duty. This gives exactly duty high ticks per period.
- R4: In density mode with a duty of at most half the period, no high pulse lasts longer than one tick.
- R5: A write (`cmp_wr_i` high with `cmp_data_i`) only updates a holding register. The holding value becomes the active duty at the next wrap, so every period uses a single duty.
- R6: The level of `mode_pdm_i` is sampled only at a wrap. A change in the middle of a period does not alter that period's waveform.
- R7: While `tick_i` is low, the counter and `dac_o` hold their values and no interrupt is raised.
- R8: When `irq_mask_i` is low at a wrap, `ovf_irq_o` is high for exactly one clock, the clock that follows the wrapping edge.
- R9: When `irq_mask_i` is high at a wrap, `ovf_irq_o` stays low.
- R10: Asserting `rst_n` low at once clears the counter, the holding and active duty, and the mode (to width mode), and drives `dac_o` and `ovf_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Counter clock enable |
| cmp_wr_i | input | 1 | Write strobe for the duty holding register |
| cmp_data_i | input | CNT_W | Duty value to write |
| mode_pdm_i | input | 1 | 0 = width mode, 1 = density mode (applied at wrap) |
| irq_mask_i | input | 1 | 1 suppresses the overflow interrupt |
| dac_o | output | 1 | DAC waveform pin |
| ovf_irq_o | output | 1 | One-clock overflow interrupt pulse |

## Verification
The bench builds the block with CNT_W = 4, so a period is only 16 ticks. At that size the bench can sweep the duty across its extreme values and several values in between, in both modes, and compare every cycle against a reference model. The short period also puts the wrap boundary within a few cycles. That lets the bench land holding-register writes and mode changes mid-period and check that they wait for the boundary. It also lets the bench interleave idle stretches of the enable with wraps and interrupt masking, at low cost.

// File: rtl/dac_timer_pkg.sv
package dac_timer_pkg;
  typedef enum logic {
    MODE_WIDTH   = 1'b0,
    MODE_DENSITY = 1'b1
  } dac_mode_e;
endpackage

// File: rtl/dac_tick_counter.sv
module dac_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end

  assign cnt_nxt_o = cnt_d;
  assign wrap_o    = tick_i && (cnt_q == CNT_MAX);

  // R7: idle enable freezes the count
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R1: count moves by one per tick
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1: wrap returns to zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/dac_duty_shadow.sv
module dac_duty_shadow
  import dac_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             mode_pdm_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] duty_q_o,
  output logic [CNT_W-1:0] duty_nxt_o,
  output dac_mode_e        mode_q_o,
  output dac_mode_e        mode_nxt_o
);
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  dac_mode_e        mode_q, mode_d;

  always_comb begin
    hold_d = hold_q;
    if (wr_i) hold_d = data_i;
    duty_d = duty_q;
    mode_d = mode_q;
    if (wrap_i) begin
      duty_d = hold_q;
      mode_d = mode_pdm_i ? MODE_DENSITY : MODE_WIDTH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      duty_q <= '0;
      mode_q <= MODE_WIDTH;
    end else begin
      if (wr_i) hold_q <= hold_d;
      if (wrap_i) begin
        duty_q <= duty_d;
        mode_q <= mode_d;
      end
    end
  end

  assign duty_q_o   = duty_q;
  assign duty_nxt_o = duty_d;
  assign mode_q_o   = mode_q;
  assign mode_nxt_o = mode_d;

  // R5: active duty only moves at a wrap
  assert_duty_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(duty_q));
  // R6: mode only moves at a wrap
  assert_mode_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(mode_q));
endmodule

// File: rtl/dac_wave_gen.sv
module dac_wave_gen
  import dac_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] duty_nxt_i,
  input  dac_mode_e        mode_nxt_i,
  input  logic [CNT_W-1:0] duty_q_i,
  input  dac_mode_e        mode_q_i,
  output logic             pin_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_rev;
  logic             pin_q, pin_d;

  for (genvar b = 0; b < CNT_W; b++) begin : g_rev
    assign cnt_rev[b] = cnt_nxt_i[CNT_W-1-b];
  end

  always_comb begin
    pin_d = pin_q;
    if (tick_i) begin
      if (mode_nxt_i == MODE_DENSITY) pin_d = (cnt_rev < duty_nxt_i);
      else                            pin_d = (cnt_nxt_i < duty_nxt_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (tick_i) pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  // R2: zero duty never drives the pin high
  assert_zero_duty_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q_i == '0) |-> !pin_q);
  // R4: density pulses are single ticks at up to half duty
  assert_pdm_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q_i == MODE_DENSITY && duty_q_i <= HALF && pin_q && tick_i) |=> !pin_q);
  // R7: pin frozen while idle
  assert_pin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pin_q));
endmodule

// File: rtl/dac_pulse_timer.sv
module dac_pulse_timer
  import dac_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             mode_pdm_i,
  input  logic             irq_mask_i,
  output logic             dac_o,
  output logic             ovf_irq_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  logic [CNT_W-1:0] duty_q, duty_nxt;
  dac_mode_e        mode_q, mode_nxt;
  logic             irq_q, irq_d;

  dac_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  dac_duty_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (cmp_wr_i),
    .data_i     (cmp_data_i),
    .mode_pdm_i (mode_pdm_i),
    .wrap_i     (wrap),
    .duty_q_o   (duty_q),
    .duty_nxt_o (duty_nxt),
    .mode_q_o   (mode_q),
    .mode_nxt_o (mode_nxt)
  );

  dac_wave_gen #(.CNT_W(CNT_W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cnt_nxt_i  (cnt_nxt),
    .duty_nxt_i (duty_nxt),
    .mode_nxt_i (mode_nxt),
    .duty_q_i   (duty_q),
    .mode_q_i   (mode_q),
    .pin_o      (dac_o)
  );

  always_comb irq_d = wrap && !irq_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign ovf_irq_o = irq_q;

  // R8: interrupt is a single-clock pulse
  assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |=> !ovf_irq_o);
  // R9: masked wrap raises nothing
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && irq_mask_i) |=> !ovf_irq_o);
  // R7: no interrupt without a tick
  assert_irq_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !ovf_irq_o);
endmodule

// File: tb/sim_dac_pulse_timer.sv
module sim_dac_pulse_timer;
  localparam int W   = 4;
  localparam int N   = 1 << W;
  localparam int MAX = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, mode = 1'b0, mask = 1'b0;
  logic [W-1:0] wdata = '0;
  logic dac, irq;

  int n_tests = 0, n_fail = 0, mism = 0;
  int m_cnt, m_hold, m_duty, m_mode, m_pin, m_irq;
  int hi_cnt, run, max_run, irq_cnt;

  always #5 clk = ~clk;

  dac_pulse_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmp_wr_i(wr),
    .cmp_data_i(wdata), .mode_pdm_i(mode), .irq_mask_i(mask),
    .dac_o(dac), .ovf_irq_o(irq)
  );

  function automatic int rev(input int v);
    int r = 0;
    for (int b = 0; b < W; b++) if (v[b]) r |= 1 << (W - 1 - b);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_hold = 0; m_duty = 0; m_mode = 0; m_pin = 0; m_irq = 0;
  endtask

  // one clock: drive, edge, update model, sample 1 ns later
  task automatic step(input bit t, input bit w, input int d);
    int old_hold;
    tick = t; wr = w; wdata = W'(d);
    @(posedge clk);
    old_hold = m_hold;
    if (w) m_hold = d;
    m_irq = 0;
    if (t) begin
      if (m_cnt == MAX) begin
        m_duty = old_hold; m_mode = mode; m_irq = !mask;
      end
      m_cnt = (m_cnt + 1) % N;
      m_pin = m_mode ? (rev(m_cnt) < m_duty) : (m_cnt < m_duty);
    end
    #1;
    if (dac !== 1'(m_pin) || irq !== 1'(m_irq)) mism++;
    if (dac) begin run++; hi_cnt++; if (run > max_run) max_run = run; end
    else run = 0;
    if (irq) irq_cnt++;
    tick = 1'b0; wr = 1'b0;
  endtask

  task automatic to_wrap();
    while (m_cnt != MAX) step(1, 0, 0);
  endtask

  task automatic one_period();
    hi_cnt = 0; run = 0; max_run = 0;
    for (int i = 0; i < N; i++) step(1, 0, 0);
  endtask

  task automatic load_duty(input int d, input bit m);
    mode = m;
    step(1, 1, d);
    to_wrap();
  endtask

  task automatic t_reset();
    chk(dac === 1'b0, "R10 pin after reset", dac, 0);
    chk(irq === 1'b0, "R10 irq after reset", irq, 0);
    mism = 0;
    one_period();
    chk(hi_cnt == 0, "R10 duty cleared", hi_cnt, 0);
    chk(mism == 0, "R1 count model after reset", mism, 0);
  endtask

  task automatic t_pwm(input int d);
    mism = 0;
    load_duty(d, 0);
    one_period();
    chk(hi_cnt == d, "R2 width high ticks", hi_cnt, d);
    chk(max_run == d, "R2 width contiguous", max_run, d);
    chk(mism == 0, "R2 width per-cycle", mism, 0);
  endtask

  task automatic t_pdm(input int d);
    mism = 0;
    load_duty(d, 1);
    one_period();
    chk(hi_cnt == d, "R3 density high ticks", hi_cnt, d);
    chk(mism == 0, "R3 density per-cycle", mism, 0);
    if (d <= N / 2) chk(max_run <= 1, "R4 single pulses", max_run, 1);
  endtask

  task automatic t_shadow();
    mism = 0;
    load_duty(3, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(1, 1, 12);
    hi_cnt = 0;
    to_wrap();
    chk(hi_cnt == 0, "R5 old duty kept mid-period", hi_cnt, 0);
    one_period();
    chk(hi_cnt == 12, "R5 new duty at wrap", hi_cnt, 12);
    chk(mism == 0, "R5 per-cycle", mism, 0);
  endtask

  task automatic t_mode();
    mism = 0;
    load_duty(8, 0);
    step(1, 0, 0);
    mode = 1'b1;
    hi_cnt = 0; run = 0; max_run = 0;
    to_wrap();
    chk(max_run == 7, "R6 width kept to wrap", max_run, 7);
    one_period();
    chk(max_run == 1, "R6 density after wrap", max_run, 1);
    chk(mism == 0, "R6 per-cycle", mism, 0);
  endtask

  task automatic t_idle();
    logic held;
    mism = 0;
    load_duty(6, 0);
    step(1, 0, 0); step(1, 0, 0);
    held = dac;
    irq_cnt = 0;
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    chk(dac === held, "R7 pin held while idle", dac, held);
    chk(irq_cnt == 0, "R7 no irq while idle", irq_cnt, 0);
    to_wrap();
    one_period();
    chk(hi_cnt == 6 && mism == 0, "R7 count resumes", hi_cnt, 6);
  endtask

  task automatic t_irq();
    mism = 0;
    mask = 1'b0;
    to_wrap();
    irq_cnt = 0;
    for (int p = 0; p < 3; p++) one_period();
    chk(irq_cnt == 3, "R8 one pulse per wrap", irq_cnt, 3);
    mask = 1'b1;
    irq_cnt = 0;
    for (int p = 0; p < 2; p++) one_period();
    chk(irq_cnt == 0, "R9 masked", irq_cnt, 0);
    mask = 1'b0;
    chk(mism == 0, "R8 timing per-cycle", mism, 0);
  endtask

  task automatic t_async_reset();
    load_duty(10, 0);
    step(1, 0, 0);
    rst_n = 1'b0;
    #1;
    chk(dac === 1'b0, "R10 async pin low", dac, 0);
    model_reset();
    mode = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pwm(0); t_pwm(1); t_pwm(5); t_pwm(MAX);
    t_pdm(1); t_pdm(5); t_pdm(N / 2); t_pdm(MAX);
    t_shadow();
    t_mode();
    t_idle();
    t_irq();
    t_async_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule